// File: doc/BRIEF.md
# Serial Boot-Mode Configuration Loader

This block reads a fixed 256-bit configuration frame from an external serial ROM as soon as the power-good input rises. It divides the system clock by 256 to make a slow serial clock for the ROM. On the system cycle in which that serial clock rises, it captures one data bit and writes it into a mode register. It flags completion after the last bit. Everything runs in the system clock domain and is advanced by a single-cycle strobe, so no second clock net exists.

Once the frame is complete, the register is frozen and three results are decoded from it:
- a pipeline clock-multiplier value, whose meaning depends on a half-step select bit;
- a two-bit output drive strength;
- an error flag for reserved bits that are set or for a multiplier code that is invalid in the selected mode.

Dropping power-good clears everything and the next rise starts a fresh load.

Top module: `cfg_loader`

## Requirements
- R1: While `pwr_good` is low, `rom_sclk` is low and no bit is captured. Loading starts on the first clock edge at which `pwr_good` is high.
- R2: `rom_sclk` has a period of 2^DIV_LOG2 system clocks (256 by default). It is low for the first half of each period, counted from the rise of `pwr_good`. It keeps running without a break while `pwr_good` stays high, including after the frame is complete.
- R3: Bit n of the frame is captured on the system edge at which `rom_sclk` rises for the (n+1)th time. It is stored in `mode_q[n]`, so bit 0 arrives first and bit 255 last.
- R4: `load_done` rises on the same edge that captures bit 255, and not before.
- R5: While `load_done` is high, `mode_q` holds its value whatever `rom_din` does, until `pwr_good` falls.
- R6: `rst_n` low or `pwr_good` low at a clock edge clears `mode_q`, the bit count and `load_done` on that edge.
- R7: With `mode_q[20]` = 0, the 3-bit code in `mode_q[7:5]` gives a multiplier of code+2. `mult_x2` reports twice the multiplier (codes 000..111 give 4..18).
- R8: With `mode_q[20]` = 1, the codes 011, 101 and 111 give `mult_x2` = 5, 7 and 9 (x2.5, x3.5, x4.5). Every other code gives `mult_x2` = 0, which means invalid.
- R9: `drive_sel` equals `mode_q[14:13]`.
- R10: `cfg_err` is high exactly when `load_done` is high and either a reserved bit is set (bit 0, bit 12, bits 255..22) or `mult_x2` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pwr_good | input | 1 | Starts loading on rise; clears state when low |
| rom_din | input | 1 | Serial data from the configuration ROM |
| rom_sclk | output | 1 | Divided serial clock to the ROM |
| mode_q | output | FRAME_BITS | Captured configuration frame |
| load_done | output | 1 | All frame bits captured |
| mult_x2 | output | 5 | Clock multiplier in half steps, 0 when invalid |
| drive_sel | output | 2 | Output driver strength field |
| cfg_err | output | 1 | Reserved bit set or invalid multiplier code, after completion |

## Verification
The assertions take for granted that `rst_n` and `pwr_good` are synchronous to `clk`. They also assume `rom_din` holds steady for at least four system clocks before each capturing edge, which the loader relies on but does not check. The stimulus changes `rom_din` only on falling system-clock edges, one slow period apart and half a slow period ahead of the capture. This leaves the setup window satisfied even with the shortened divider used on the second instance. `pwr_good` is also toggled only on falling edges, so the clear and start behaviour is seen on a well-defined edge.

// File: rtl/cfgload_pkg.sv
// Package: shared types and decode helpers for the configuration loader.
// Assumes the frame is wider than the highest named field (bit 21).
package cfgload_pkg;

    typedef logic [4:0] mult_half_t;   // multiplier expressed in half steps

    localparam int MULT_LSB  = 5;
    localparam int MULT_W    = 3;
    localparam int HALF_BIT  = 20;
    localparam int DRV_LSB   = 13;
    localparam int RSV_LOW   = 22;     // first bit of the upper reserved range
    localparam int RSV_A     = 0;
    localparam int RSV_B     = 12;

    // Multiplier decode: 0 marks an invalid code for the selected mode.
    function automatic mult_half_t mult_decode(input logic [MULT_W-1:0] code,
                                               input logic half_sel);
        mult_half_t r;
        if (!half_sel) begin
            r = mult_half_t'({code, 1'b0}) + mult_half_t'(4);
        end else begin
            case (code)
                3'b011:  r = mult_half_t'(5);
                3'b101:  r = mult_half_t'(7);
                3'b111:  r = mult_half_t'(9);
                default: r = '0;
            endcase
        end
        return r;
    endfunction

endpackage

// File: rtl/cfgload_sclk.sv
// Serial clock divider: counts system clocks while power-good is high and
// drives the ROM clock from the counter MSB. Emits a one-cycle capture
// strobe on the cycle whose edge makes the serial clock rise.
// Assumes pwr_good is synchronous to clk.
module cfgload_sclk #(
    parameter int DIV_LOG2 = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pwr_good,
    output logic sclk,
    output logic sample_en
);
    localparam int W = DIV_LOG2;
    localparam logic [W-1:0] RISE_PREV = {1'b0, {(W-1){1'b1}}};

    logic [W-1:0] div_cnt;

    // Free-running divider, held at zero while power is not good.
    always_ff @(posedge clk) begin
        if (!rst_n || !pwr_good) div_cnt <= '0;
        else                     div_cnt <= div_cnt + 1'b1;
    end

    assign sclk      = div_cnt[W-1];
    assign sample_en = pwr_good && (div_cnt == RISE_PREV);

    a_r1_sclk_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_good |=> !sclk);

    a_r2_strobe_at_rise: assert property (@(posedge clk) disable iff (!rst_n)
        sample_en |=> $rose(sclk));

endmodule

// File: rtl/cfgload_frame.sv
// Frame capture: writes one bit per strobe into the mode register at the
// position given by the bit count, and raises done after the last bit.
// Freezes until power-good falls. Assumes sample_en is one cycle wide.
module cfgload_frame #(
    parameter int FRAME_BITS = 256
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  pwr_good,
    input  logic                  sample_en,
    input  logic                  din,
    output logic [FRAME_BITS-1:0] mode_q,
    output logic                  done
);
    localparam int CW = $clog2(FRAME_BITS);
    localparam logic [CW-1:0] LAST = CW'(FRAME_BITS - 1);

    logic [CW-1:0] bit_cnt;

    // Capture one bit per strobe; stop advancing once the frame is complete.
    always_ff @(posedge clk) begin
        if (!rst_n || !pwr_good) begin
            bit_cnt <= '0;
            mode_q  <= '0;
            done    <= 1'b0;
        end else if (sample_en && !done) begin
            mode_q[bit_cnt] <= din;
            if (bit_cnt == LAST) done    <= 1'b1;
            else                 bit_cnt <= bit_cnt + 1'b1;
        end
    end

    a_r5_frozen_after_done: assert property (@(posedge clk) disable iff (!rst_n)
        (done && pwr_good) |=> (!pwr_good || $past(!pwr_good) || (done && $stable(mode_q))));

    a_r6_clear_on_power_drop: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_good |=> (mode_q == '0 && !done));

endmodule

// File: rtl/cfgload_decode.sv
// Mode decode: derives the multiplier, drive strength and error flag from
// the captured frame. Assumes FRAME_BITS exceeds the upper reserved start.
module cfgload_decode
    import cfgload_pkg::*;
#(
    parameter int FRAME_BITS = 256
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [FRAME_BITS-1:0] mode_q,
    input  logic                  done,
    output mult_half_t            mult_x2,
    output logic [1:0]            drive_sel,
    output logic                  cfg_err
);
    // Build the reserved-bit mask from the named positions.
    function automatic logic [FRAME_BITS-1:0] rsv_mask();
        logic [FRAME_BITS-1:0] m;
        m = '0;
        for (int i = 0; i < FRAME_BITS; i++)
            if (i >= RSV_LOW || i == RSV_A || i == RSV_B) m[i] = 1'b1;
        return m;
    endfunction

    localparam logic [FRAME_BITS-1:0] RSV_MASK = rsv_mask();

    logic rsv_hit;

    // Combinational field decode.
    always_comb begin
        mult_x2   = mult_decode(mode_q[MULT_LSB +: MULT_W], mode_q[HALF_BIT]);
        drive_sel = mode_q[DRV_LSB +: 2];
        rsv_hit   = |(mode_q & RSV_MASK);
        cfg_err   = done && (rsv_hit || (mult_x2 == '0));
    end

    a_r10_bad_mult_flagged: assert property (@(posedge clk) disable iff (!rst_n)
        (done && mult_x2 == '0) |-> cfg_err);

    a_r10_no_err_before_done: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> !cfg_err);

endmodule

// File: rtl/cfg_loader.sv
// Top: serial boot-mode configuration loader. Divides the system clock for
// the ROM, captures a fixed-length frame after power-good, then decodes it.
// Assumes rst_n, pwr_good and rom_din are synchronous to clk.
module cfg_loader #(
    parameter int FRAME_BITS = 256,
    parameter int DIV_LOG2   = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  pwr_good,
    input  logic                  rom_din,
    output logic                  rom_sclk,
    output logic [FRAME_BITS-1:0] mode_q,
    output logic                  load_done,
    output logic [4:0]            mult_x2,
    output logic [1:0]            drive_sel,
    output logic                  cfg_err
);
    logic sample_en;

    cfgload_sclk #(.DIV_LOG2(DIV_LOG2)) u_sclk (
        .clk       (clk),
        .rst_n     (rst_n),
        .pwr_good  (pwr_good),
        .sclk      (rom_sclk),
        .sample_en (sample_en)
    );

    cfgload_frame #(.FRAME_BITS(FRAME_BITS)) u_frame (
        .clk       (clk),
        .rst_n     (rst_n),
        .pwr_good  (pwr_good),
        .sample_en (sample_en),
        .din       (rom_din),
        .mode_q    (mode_q),
        .done      (load_done)
    );

    cfgload_decode #(.FRAME_BITS(FRAME_BITS)) u_dec (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode_q    (mode_q),
        .done      (load_done),
        .mult_x2   (mult_x2),
        .drive_sel (drive_sel),
        .cfg_err   (cfg_err)
    );

endmodule

// File: tb/sim_cfg_loader.sv
// Directed bench: u0 runs at the default divide-by-256, u1 uses divide-by-8
// to cover many decode patterns quickly.
module sim_cfg_loader;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pg0 = 1'b0, din0 = 1'b0, pg1 = 1'b0, din1 = 1'b0;
    logic sclk0, sclk1, done0, done1, err0, err1;
    logic [255:0] mode0, mode1;
    logic [4:0] mult0, mult1;
    logic [1:0] drv0, drv1;
    int n_chk = 0, n_fail = 0;
    bit finished = 0;

    always #10 clk = ~clk;   // 50 MHz

    cfg_loader u0 (.clk(clk), .rst_n(rst_n), .pwr_good(pg0), .rom_din(din0),
        .rom_sclk(sclk0), .mode_q(mode0), .load_done(done0), .mult_x2(mult0),
        .drive_sel(drv0), .cfg_err(err0));

    cfg_loader #(.DIV_LOG2(3)) u1 (.clk(clk), .rst_n(rst_n), .pwr_good(pg1),
        .rom_din(din1), .rom_sclk(sclk1), .mode_q(mode1), .load_done(done1),
        .mult_x2(mult1), .drive_sel(drv1), .cfg_err(err1));

    task automatic check(input bit ok, input string req, input string what,
                         input logic [255:0] act, input logic [255:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic ticks(input int k);
        repeat (k) @(negedge clk);
    endtask

    function automatic logic g_sclk(input bit f); return f ? sclk1 : sclk0; endfunction
    function automatic logic g_done(input bit f); return f ? done1 : done0; endfunction
    function automatic logic [255:0] g_mode(input bit f); return f ? mode1 : mode0; endfunction

    task automatic drive(input bit f, input logic pg, input logic d);
        if (f) begin pg1 = pg; din1 = d; end
        else   begin pg0 = pg; din0 = d; end
    endtask

    // Load one full frame; checks serial clock phase, capture and done timing.
    task automatic load_frame(input bit f, input logic [255:0] fr);
        int p = f ? 8 : 256;
        int h = p / 2;
        for (int n = 0; n < 256; n++) begin
            drive(f, 1'b1, fr[n]);
            if (n == 0) begin
                ticks(h - 1);
                check(g_sclk(f) == 1'b0, "R2", "sclk low first half", g_sclk(f), 0);
                check(g_mode(f) == '0, "R3", "nothing captured before rise", g_mode(f), 0);
                ticks(1);
                check(g_sclk(f) == 1'b1, "R2", "sclk rises at half", g_sclk(f), 1);
                check(g_mode(f)[0] == fr[0], "R3", "bit0 captured on rise", g_mode(f)[0], fr[0]);
                ticks(h);
                check(g_sclk(f) == 1'b0, "R2", "sclk falls at period", g_sclk(f), 0);
            end else if (n == 255) begin
                ticks(h - 1);
                check(g_done(f) == 1'b0, "R4", "done not before last bit", g_done(f), 0);
                ticks(1);
                check(g_done(f) == 1'b1, "R4", "done on last capture", g_done(f), 1);
                ticks(h);
            end else begin
                ticks(p);
            end
        end
        check(g_mode(f) == fr, "R3", "frame order", g_mode(f), fr);
    endtask

    task automatic power_off(input bit f);
        drive(f, 1'b0, 1'b0);
        ticks(1);
        check(g_mode(f) == '0 && g_done(f) == 1'b0, "R6", "clear on power drop",
              {g_done(f), g_mode(f)[254:0]}, 0);
        ticks(2);
    endtask

    function automatic logic [255:0] mk(input logic [2:0] code, input logic half,
                                        input logic [1:0] drv);
        logic [255:0] r = '0;
        r[7:5] = code; r[20] = half; r[14:13] = drv;
        return r;
    endfunction

    task automatic t_reset();
        ticks(4);
        check(sclk0 == 1'b0 && sclk1 == 1'b0, "R1", "sclk idle in reset", {sclk0, sclk1}, 0);
        check(done0 == 1'b0 && mode0 == '0, "R6", "reset state", mode0, 0);
        rst_n = 1'b1;
        ticks(5);
        check(sclk0 == 1'b0 && mode0 == '0, "R1", "idle while power not good", {sclk0, mode0[0]}, 0);
    endtask

    // Default-rate frame, then freeze and continuous-clock check.
    task automatic t_full_rate();
        logic [255:0] fr = mk(3'b011, 1'b0, 2'b10);
        int hi = 0;
        fr[3] = 1; fr[11] = 1; fr[19:15] = 5'b10101; fr[21] = 1;
        load_frame(0, fr);
        check(mult0 == 5'd10, "R7", "code 011 normal -> x5", mult0, 10);
        check(drv0 == 2'b10, "R9", "drive field", drv0, 2);
        check(err0 == 1'b0, "R10", "clean frame no error", err0, 0);
        din0 = ~din0;
        for (int i = 0; i < 768; i++) begin
            ticks(1);
            if (sclk0) hi++;
            din0 = ~din0;
        end
        check(hi == 384, "R2", "sclk keeps running after done", hi, 384);
        check(mode0 == fr && done0, "R5", "frame frozen after done", mode0, fr);
        power_off(0);
    endtask

    task automatic t_decode(input logic [2:0] code, input logic half,
                            input logic [4:0] exp_m, input string req);
        logic [255:0] fr = mk(code, half, 2'b01);
        load_frame(1, fr);
        check(mult1 == exp_m, req, "multiplier decode", mult1, exp_m);
        check(err1 == (exp_m == 0), "R10", "error from multiplier", err1, exp_m == 0);
        check(drv1 == 2'b01, "R9", "drive field", drv1, 1);
        power_off(1);
    endtask

    task automatic t_reserved(input int pos);
        logic [255:0] fr = mk(3'b000, 1'b0, 2'b11);
        fr[pos] = 1'b1;
        load_frame(1, fr);
        check(err1 == 1'b1, "R10", $sformatf("reserved bit %0d", pos), err1, 1);
        check(mult1 == 5'd4, "R7", "code 000 normal -> x2", mult1, 4);
        power_off(1);
    endtask

    task automatic t_abort();
        drive(1, 1'b1, 1'b1);
        ticks(40);
        check(mode1[4:0] == 5'b11111 && done1 == 1'b0, "R3", "partial capture", mode1[4:0], 5'h1f);
        power_off(1);
        check(sclk1 == 1'b0, "R1", "sclk stops when power drops", sclk1, 0);
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_full_rate();
        t_decode(3'b111, 1'b0, 5'd18, "R7");
        t_decode(3'b010, 1'b0, 5'd8,  "R7");
        t_decode(3'b011, 1'b1, 5'd5,  "R8");
        t_decode(3'b101, 1'b1, 5'd7,  "R8");
        t_decode(3'b111, 1'b1, 5'd9,  "R8");
        t_decode(3'b010, 1'b1, 5'd0,  "R8");
        t_decode(3'b000, 1'b1, 5'd0,  "R8");
        t_reserved(0);
        t_reserved(12);
        t_reserved(22);
        t_reserved(255);
        t_abort();
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule